// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Selectable Framing

This block is the transmit side of a stereo serial audio link, and it acts as the clock master. It takes left/right sample pairs from a small FIFO and produces three outputs: a bit clock, a channel-select clock and a serial data line. The bit clock is made from the system clock by a programmable divider. Each channel occupies a half-frame of 16 to 32 bit clocks.

Three framings share one serial path:
- The standard delayed framing places the MSB one bit clock after the channel-select edge.
- The left-aligned framing places the MSB on the same bit clock as that edge.
- The right-aligned framing places the LSB in the last bit clock before the next edge.

Samples are 8 or 16 bits per channel, in two's complement, MSB first. Slots that carry no sample bits are driven to zero.

Software or a DMA engine fills the FIFO through a single push strobe. It watches the full flag and a low-level request to decide when to push. If a frame must start while the FIFO is empty, the block sends silence and raises a sticky flag.

Top module: `aud_i2s_tx`

## Requirements
- R1: While `enable` is high, `bclk` has a period of 2*(`half_div`+1) system clocks with equal high and low phases.
- R2: `lrclk` is low while the left channel is sent and high while the right channel is sent. Each half-frame lasts H bit clocks, where H is `half_len` clamped to the range 16..32.
- R3: `sdata` and `lrclk` change only in the system clock cycle where `bclk` falls, so a receiver can sample them on the rising edge of `bclk`.
- R4: With `fmt`=2'd0 (delayed framing), the MSB of a channel word is in the second bit clock of its half-frame. The LSB of a full-length word may therefore fall in the first bit clock of the following half-frame.
- R5: With `fmt`=2'd1 (left-aligned framing), the MSB is in the first bit clock of the half-frame. The value 2'd3 behaves the same way.
- R6: With `fmt`=2'd2 (right-aligned framing), the LSB is in the last bit clock of the half-frame.
- R7: With `wide`=1, all 16 bits of the pushed channel field are sent. With `wide`=0, only bits [7:0] are sent and bits [15:8] have no effect. Every bit clock outside the word is driven to 0.
- R8: A high `push` writes one {left, right} pair into a FIFO of FIFO_DEPTH entries, unless `fifo_full` is high, in which case the push is ignored. One pair is removed at the start of each frame, in push order.
- R9: `low_req` is high exactly when the FIFO holds LOW_MARK pairs or fewer.
- R10: A frame that starts while the FIFO is empty sends zeros on both channels and sets `underrun`. The flag stays high until `underrun_clr` is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R11: While `enable` is low, `bclk` and `sdata` are 0, `lrclk` is 1, and the FIFO keeps its contents. The first bit clock after enabling begins a left half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the transmitter; low holds it idle |
| fmt | input | 2 | Framing: 0 delayed, 1 left-aligned, 2 right-aligned, 3 as 1 |
| wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| half_len | input | 6 | Bit clocks per half-frame, clamped to 16..32 |
| half_div | input | DIV_W | System clocks per bit-clock phase, minus one |
| push | input | 1 | Write strobe for one sample pair |
| push_left | input | 16 | Left sample |
| push_right | input | 16 | Right sample |
| underrun_clr | input | 1 | Clears the underrun flag |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH pairs |
| low_req | output | 1 | FIFO level at or below LOW_MARK |
| underrun | output | 1 | Sticky: a frame started with an empty FIFO |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Channel select: low = left |
| sdata | output | 1 | Serial data |

## Verification
The same patterns are sent in each framing: 16-bit words at the minimum half-frame length, where the delayed framing carries the LSB over into the next half, and 8-bit words in longer half-frames, where the leading and trailing zero padding separates left-aligned from right-aligned placement. Sample values have set bits in both bytes and differ between channels. A wrong bit order, a wrong channel, or high bytes leaking into an 8-bit word each show up as a mismatch in a specific half-frame. An over-filled FIFO combined with more frames than queued pairs checks both that a push into a full FIFO is dropped and that an underrun sends silence. Out-of-range half lengths check the clamping, and several divider values check the bit-clock period.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic [1:0] {
    FMT_DELAYED = 2'd0,
    FMT_LEFT    = 2'd1,
    FMT_RIGHT   = 2'd2,
    FMT_LEFT_B  = 2'd3
  } fmt_e;

  localparam int SAMPLE_W = 16;
  localparam logic [5:0] HALF_MIN = 6'd16;
  localparam logic [5:0] HALF_MAX = 6'd32;

  // Limits the requested half-frame length to the supported range.
  function automatic logic [5:0] clamp_half(input logic [5:0] req);
    if (req < HALF_MIN) return HALF_MIN;
    if (req > HALF_MAX) return HALF_MAX;
    return req;
  endfunction

  // Returns the bit carried in slot 'pos' of a half-frame, for left or right alignment.
  function automatic logic slot_bit(input logic [SAMPLE_W-1:0] word, input logic wide,
                                    input logic right_align, input logic [5:0] hlen,
                                    input logic [5:0] pos);
    logic [5:0] wlen;
    logic [5:0] lead;
    logic [5:0] k;
    logic [5:0] idx;
    wlen = wide ? 6'd16 : 6'd8;
    lead = right_align ? (hlen - wlen) : 6'd0;
    if (pos < lead) return 1'b0;
    k = pos - lead;
    if (k >= wlen) return 1'b0;
    idx = wlen - 6'd1 - k;
    return word[idx[3:0]];
  endfunction

endpackage

// File: rtl/aud_tx_fifo.sv
module aud_tx_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  parameter int LOW_MARK = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic             low
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign low   = (count <= CW'(LOW_MARK));
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/aud_tx_bitclk.sv
module aud_tx_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] half_div,
  output logic             bclk,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             phase_end;

  assign phase_end = (cnt >= half_div);
  assign fall_tick = enable && phase_end && bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (!enable) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (phase_end) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
  import aud_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                tick,
  input  logic [1:0]          fmt,
  input  logic                wide,
  input  logic [5:0]          hlen,
  input  logic                src_empty,
  input  logic [SAMPLE_W-1:0] src_left,
  input  logic [SAMPLE_W-1:0] src_right,
  output logic                pop,
  output logic                starve,
  output logic                lrclk,
  output logic                sdata
);
  logic                side;
  logic [5:0]          pos;
  logic [SAMPLE_W-1:0] word_l, word_r;
  logic                lag_bit;

  logic                last_slot, next_side, frame_start;
  logic [5:0]          next_pos;
  logic [SAMPLE_W-1:0] cur_l, cur_r, cur_word;
  logic                aligned_bit, out_bit;

  assign last_slot   = (pos >= hlen - 6'd1);
  assign next_side   = last_slot ? ~side : side;
  assign next_pos    = last_slot ? 6'd0 : pos + 6'd1;
  assign frame_start = last_slot && side;
  assign cur_l       = frame_start ? (src_empty ? '0 : src_left)  : word_l;
  assign cur_r       = frame_start ? (src_empty ? '0 : src_right) : word_r;
  assign cur_word    = next_side ? cur_r : cur_l;
  assign aligned_bit = slot_bit(cur_word, wide, fmt == FMT_RIGHT, hlen, next_pos);
  assign out_bit     = (fmt == FMT_DELAYED) ? lag_bit : aligned_bit;
  assign pop         = tick && frame_start && !src_empty;
  assign starve      = tick && frame_start && src_empty;
  assign lrclk       = side;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      side    <= 1'b1;
      pos     <= 6'h3F;
      word_l  <= '0;
      word_r  <= '0;
      lag_bit <= 1'b0;
      sdata   <= 1'b0;
    end else if (!enable) begin
      side    <= 1'b1;
      pos     <= 6'h3F;
      lag_bit <= 1'b0;
      sdata   <= 1'b0;
    end else if (tick) begin
      side    <= next_side;
      pos     <= next_pos;
      word_l  <= cur_l;
      word_r  <= cur_r;
      lag_bit <= aligned_bit;
      sdata   <= out_bit;
    end
  end
endmodule

// File: rtl/aud_i2s_tx.sv
module aud_i2s_tx
  import aud_tx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int LOW_MARK   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       fmt,
  input  logic             wide,
  input  logic [5:0]       half_len,
  input  logic [DIV_W-1:0] half_div,
  input  logic             push,
  input  logic [15:0]      push_left,
  input  logic [15:0]      push_right,
  input  logic             underrun_clr,
  output logic             fifo_full,
  output logic             low_req,
  output logic             underrun,
  output logic             bclk,
  output logic             lrclk,
  output logic             sdata
);
  localparam int PAIR_W = 2 * SAMPLE_W;

  logic              fall_tick;
  logic              pop_evt;
  logic              starve_evt;
  logic              fifo_empty;
  logic [PAIR_W-1:0] head;
  logic [5:0]        hlen;

  assign hlen = clamp_half(half_len);

  aud_tx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
    .bclk(bclk), .fall_tick(fall_tick)
  );

  aud_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(PAIR_W), .LOW_MARK(LOW_MARK)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(push), .wdata({push_left, push_right}),
    .rd(pop_evt), .rdata(head), .empty(fifo_empty), .full(fifo_full), .low(low_req)
  );

  aud_tx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(fall_tick),
    .fmt(fmt), .wide(wide), .hlen(hlen),
    .src_empty(fifo_empty), .src_left(head[PAIR_W-1:SAMPLE_W]), .src_right(head[SAMPLE_W-1:0]),
    .pop(pop_evt), .starve(starve_evt), .lrclk(lrclk), .sdata(sdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          underrun <= 1'b0;
    else if (starve_evt) underrun <= 1'b1;
    else if (underrun_clr) underrun <= 1'b0;
  end
endmodule

// File: rtl/aud_i2s_tx_chk.sv
module aud_i2s_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic underrun_clr,
  input logic underrun,
  input logic bclk,
  input logic lrclk,
  input logic sdata
);
  assert_lr_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && lrclk != $past(lrclk)) |-> $fell(bclk));

  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && sdata != $past(sdata)) |-> $fell(bclk));

  assert_idle_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bclk && !sdata && lrclk));

  assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);

  assert_underrun_at_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $fell(lrclk));
endmodule

bind aud_i2s_tx aud_i2s_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .underrun_clr(underrun_clr),
  .underrun(underrun), .bclk(bclk), .lrclk(lrclk), .sdata(sdata)
);

// File: tb/tb_aud_i2s_tx.sv
module tb_aud_i2s_tx;
  localparam int DEPTH = 4;
  localparam int LOWM  = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic wide = 1'b1;
  logic [5:0] half_len = 6'd16;
  logic [7:0] half_div = 8'd1;
  logic push = 1'b0;
  logic [15:0] push_left = '0, push_right = '0;
  logic underrun_clr = 1'b0;
  logic fifo_full, low_req, underrun, bclk, lrclk, sdata;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  logic [15:0] ml [8];
  logic [15:0] mr [8];
  int mcount = 0;
  int tH, tW, tfmt;

  logic cap_lr [512];
  logic cap_sd [512];
  int rise_t [4];

  aud_i2s_tx dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fmt(fmt), .wide(wide),
    .half_len(half_len), .half_div(half_div), .push(push),
    .push_left(push_left), .push_right(push_right), .underrun_clr(underrun_clr),
    .fifo_full(fifo_full), .low_req(low_req), .underrun(underrun),
    .bclk(bclk), .lrclk(lrclk), .sdata(sdata)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    report();
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_pair(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    push = 1'b1; push_left = l; push_right = r;
    if (mcount < DEPTH) begin ml[mcount] = l; mr[mcount] = r; mcount++; end
    @(negedge clk);
    push = 1'b0;
  endtask

  function automatic logic [15:0] word_of(input int h);
    int f;
    f = h / 2;
    if (f >= mcount) return 16'h0;
    return (h % 2 == 1) ? mr[f] : ml[f];
  endfunction

  function automatic logic left_bit(input int g);
    int p, i;
    logic [15:0] w;
    p = g % tH;
    w = word_of(g / tH);
    i = tW - 1 - p;
    if (i < 0) return 1'b0;
    return w[i];
  endfunction

  function automatic logic exp_bit(input int g);
    int p, q;
    logic [15:0] w;
    if (tfmt == 0) return (g == 0) ? 1'b0 : left_bit(g - 1);
    if (tfmt == 2) begin
      p = g % tH;
      q = tH - 1 - p;
      w = word_of(g / tH);
      return (q < tW) ? w[q] : 1'b0;
    end
    return left_bit(g);
  endfunction

  // Runs nframes frames; FIFO model contents in ml/mr/mcount are consumed.
  task automatic run_stream(input string tag, input logic [1:0] f, input logic wd,
                            input logic [5:0] hl, input int expH, input logic [7:0] dv,
                            input int nframes);
    int total, k, nr;
    logic prev;
    logic [31:0] got, exp;
    logic lr_ok;
    fmt = f; wide = wd; half_len = hl; half_div = dv;
    tH = expH; tW = wd ? 16 : 8; tfmt = (f == 2'd3) ? 1 : int'(f);
    total = 2 * expH * nframes;
    @(negedge clk); underrun_clr = 1'b1;
    @(negedge clk); underrun_clr = 1'b0;
    enable = 1'b1;
    prev = 1'b0; k = 0; nr = 0;
    while (k < total + 1) begin
      @(negedge clk);
      if (bclk && !prev) begin
        if (nr < 4) rise_t[nr] = cyc;
        nr++;
        if (k > 0) begin cap_lr[k-1] = lrclk; cap_sd[k-1] = sdata; end
        k++;
      end
      prev = bclk;
    end
    enable = 1'b0;
    // R1: bit clock period
    check({tag, " R1 bclk period"}, 32'(rise_t[3] - rise_t[2]), 32'(2 * (int'(dv) + 1)));
    for (int h = 0; h < 2 * nframes; h++) begin
      got = '0; exp = '0; lr_ok = 1'b1;
      for (int p = 0; p < expH; p++) begin
        got[p] = cap_sd[h * expH + p];
        exp[p] = exp_bit(h * expH + p);
        if (cap_lr[h * expH + p] !== logic'(h % 2)) lr_ok = 1'b0;
      end
      // R2 channel select level per half-frame; R4/R5/R6/R7 data placement
      check({tag, " R2 lrclk level over half"}, 32'(lr_ok), 32'd1);
      check({tag, " R4/R5/R6/R7 half-frame bits"}, got, exp);
    end
    // R10: underrun only when frames outnumber queued pairs
    check({tag, " R10 underrun flag"}, 32'(underrun), 32'(nframes > mcount));
    mcount = 0;
  endtask

  task automatic t_reset();
    check("R11 reset bclk", 32'(bclk), 32'd0);
    check("R11 reset lrclk", 32'(lrclk), 32'd1);
    check("R11 reset sdata", 32'(sdata), 32'd0);
    check("R10 reset underrun", 32'(underrun), 32'd0);
    check("R9 reset low_req", 32'(low_req), 32'd1);
    check("R8 reset fifo_full", 32'(fifo_full), 32'd0);
  endtask

  task automatic t_overfill_delayed();
    push_pair(16'hA5C3, 16'h1E0F);
    check("R9 low_req at level 1", 32'(low_req), 32'd1);
    push_pair(16'h8001, 16'h7FFE);
    check("R9 low_req at level 2", 32'(low_req), 32'd0);
    push_pair(16'h3C96, 16'hC369);
    push_pair(16'hFFFF, 16'h0001);
    check("R8 fifo_full at depth", 32'(fifo_full), 32'd1);
    push_pair(16'h1234, 16'h5678); // R8: ignored while full
    run_stream("delayed16", 2'd0, 1'b1, 6'd16, 16, 8'd1, 5);
    check("R9 low_req after drain", 32'(low_req), 32'd1);
  endtask

  task automatic t_clear_underrun();
    @(negedge clk); underrun_clr = 1'b1;
    @(negedge clk); underrun_clr = 1'b0;
    check("R10 underrun cleared", 32'(underrun), 32'd0);
  endtask

  task automatic t_left16();
    push_pair(16'hB2D4, 16'h4E71);
    push_pair(16'h0F0F, 16'hF0F1);
    run_stream("left16", 2'd1, 1'b1, 6'd24, 24, 8'd0, 2);
  endtask

  task automatic t_right8();
    push_pair(16'hFF5A, 16'h00C3);
    push_pair(16'h1281, 16'hEE7E);
    run_stream("right8", 2'd2, 1'b0, 6'd20, 20, 8'd2, 2);
  endtask

  task automatic t_delayed8_long();
    push_pair(16'h7781, 16'h88C1);
    push_pair(16'h0080, 16'h0001);
    run_stream("delayed8", 2'd0, 1'b0, 6'd32, 32, 8'd1, 2);
  endtask

  task automatic t_clamp();
    push_pair(16'hC001, 16'h3FFE);
    run_stream("clamp_low", 2'd3, 1'b1, 6'd10, 16, 8'd1, 1);
    push_pair(16'h9669, 16'h6996);
    run_stream("clamp_high", 2'd2, 1'b1, 6'd40, 32, 8'd0, 1);
  endtask

  task automatic t_idle();
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bclk || sdata || !lrclk) bad = 1'b1;
    end
    check("R11 idle outputs held", 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_overfill_delayed();
    t_clear_underrun();
    t_left16();
    t_right8();
    t_delayed8_long();
    t_clamp();
    t_idle();
    report();
  end
endmodule